// File: doc/BRIEF.md
# Flag-Generating 16-bit ALU

This block is the arithmetic and logic stage of a small processor datapath. Each cycle it takes an opcode, a width select and two operands, and produces a result at once from combinational logic. When the caller marks the operation valid, the block also updates a set of five stored status flags on the next rising clock edge. Those flags are carry, zero, negative, signed overflow and digit carry, and they are all computed at the selected width. A mask output tells the caller which of the five flags the current opcode is allowed to change. Flags outside that mask keep their old value.

The block supports addition and subtraction, each with and without the stored carry, three bitwise logic operations, and three single-bit shifts. In byte mode only the low 8 bits of each operand take part, and the upper byte of the result is forced to zero. On subtraction the carry flag and the digit-carry flag carry "no borrow" meaning: a value of 1 means nothing was borrowed. Chained subtraction therefore feeds the stored carry back in as its not-borrow input. Operand fetch and instruction decode are done by the surrounding datapath.

Top module: `alu16_flag_core`

## Requirements
- R1: Opcode 0 (ADD) gives a+b and opcode 1 (ADC) gives a+b+C, where C is the stored carry flag. C is loaded with the carry out of the top bit of the selected width.
- R2: Opcode 2 (SUB) gives a-b and opcode 3 (SBB) gives a-b-(1-C). For both, C is loaded with 1 when no borrow occurs and with 0 when a borrow occurs.
- R3: The OV flag of an arithmetic opcode is 1 exactly when the two's-complement result at the selected width overflows, that is, when the operands' signs (for subtraction, a and the inverted b) agree and the result's sign differs from them.
- R4: The DC flag of an arithmetic opcode is the carry out of bit 3 into bit 4. On subtraction it reads as 1 when there is no nibble borrow.
- R5: In byte mode (byte_mode=1), result[15:8] is zero. C comes from the carry out of bit 7, N is result bit 7, and Z is 1 when result[7:0] is zero. In word mode, N is bit 15 and Z covers all 16 bits.
- R6: Opcodes 4 (AND), 5 (OR) and 6 (XOR) update only Z and N. C, OV and DC keep their values.
- R7: Opcodes 7 (SHL), 8 (SHR) and 9 (SAR) shift by one bit at the selected width. C is loaded with the bit shifted out. SHL and SHR fill the vacated bit with carry_in, and SAR copies the sign bit. OV and DC keep their values.
- R8: flag_mask uses bit order {C,Z,N,OV,DC} (bit 4 down to bit 0). It is 11111 for opcodes 0-3, 01100 for opcodes 4-6, 11100 for opcodes 7-9, and 00000 for opcodes 10-15. Opcodes 10-15 give result 0 and change no flag.
- R9: Flags change only on a rising clock edge while op_valid=1. With op_valid=0 every flag keeps its value.
- R10: While rst_n=0, all five flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_valid | input | 1 | Commits this cycle's flags on the next edge |
| op_code | input | 4 | Operation select, encoding per R1-R8 |
| byte_mode | input | 1 | 1 = 8-bit operation, 0 = 16-bit |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand (ignored by shifts) |
| carry_in | input | 1 | Fill bit for SHL and SHR |
| result | output | 16 | Combinational result |
| flag_mask | output | 5 | Flags the current opcode may change, {C,Z,N,OV,DC} |
| flag_c | output | 1 | Stored carry / not-borrow |
| flag_z | output | 1 | Stored zero |
| flag_n | output | 1 | Stored negative |
| flag_ov | output | 1 | Stored signed overflow |
| flag_dc | output | 1 | Stored digit carry / not-digit-borrow |

## Verification
The embedded properties check, on every cycle, the rules that hold whatever the operand values are. The flags hold while op_valid is low, and each flag outside the mask holds on a valid cycle. The upper byte is zero in byte mode. Logic and unused opcodes produce the expected mask. The top bit shifted out by SHL lands in carry. A word subtraction with a not below b never signals a borrow, and a word add of opposite-signed operands never overflows. Exact values of result and flags need the bench's scenarios: boundary operands around 0x7FFF, 0x8000, 0xFFFF and 0x7F/0x80; ADC and SBB chained on a carry left by the previous operation; nibble borrows; and the state that flags carry across logic and shift operations.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int FLAG_N = 5;
    localparam int FL_C   = 4;
    localparam int FL_Z   = 3;
    localparam int FL_N   = 2;
    localparam int FL_OV  = 1;
    localparam int FL_DC  = 0;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_SHL = 4'd7,
        OP_SHR = 4'd8,
        OP_SAR = 4'd9
    } alu_op_e;

    localparam logic [FLAG_N-1:0] MASK_ARITH = 5'b11111;
    localparam logic [FLAG_N-1:0] MASK_LOGIC = 5'b01100;
    localparam logic [FLAG_N-1:0] MASK_SHIFT = 5'b11100;
    localparam logic [FLAG_N-1:0] MASK_NONE  = 5'b00000;

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    input  logic              cin_i,
    input  logic              byte_i,
    output logic [DATA_W-1:0] res_o,
    output logic              c_o,
    output logic              ov_o,
    output logic              dc_o
);
    localparam int HI_W = DATA_W - BYTE_W;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   sum_w;
    logic [BYTE_W:0]   sum_b;
    logic [NIB_W:0]    sum_n;
    logic              msb_a, msb_b, msb_r;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        sum_w = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin_i};
        sum_b = {1'b0, a_i[BYTE_W-1:0]} + {1'b0, b_eff[BYTE_W-1:0]}
              + {{BYTE_W{1'b0}}, cin_i};
        sum_n = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]}
              + {{NIB_W{1'b0}}, cin_i};
        if (byte_i) begin
            res_o = {{HI_W{1'b0}}, sum_b[BYTE_W-1:0]};
            c_o   = sum_b[BYTE_W];
            msb_a = a_i[BYTE_W-1];
            msb_b = b_eff[BYTE_W-1];
            msb_r = sum_b[BYTE_W-1];
        end else begin
            res_o = sum_w[DATA_W-1:0];
            c_o   = sum_w[DATA_W];
            msb_a = a_i[DATA_W-1];
            msb_b = b_eff[DATA_W-1];
            msb_r = sum_w[DATA_W-1];
        end
        ov_o = (msb_a == msb_b) && (msb_r != msb_a);
        dc_o = sum_n[NIB_W];
    end

endmodule

// File: rtl/alu16_shlog.sv
module alu16_shlog
    import alu16_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  alu_op_e           op_i,
    input  logic              byte_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              fill_i,
    output logic [DATA_W-1:0] res_o,
    output logic              c_o
);
    localparam int HI_W = DATA_W - BYTE_W;

    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] keep;

    always_comb begin
        keep = byte_i ? {{HI_W{1'b0}}, {BYTE_W{1'b1}}} : {DATA_W{1'b1}};
        raw  = '0;
        c_o  = 1'b0;
        case (op_i)
            OP_AND: raw = a_i & b_i;
            OP_OR:  raw = a_i | b_i;
            OP_XOR: raw = a_i ^ b_i;
            OP_SHL: begin
                if (byte_i) begin
                    raw = {{HI_W{1'b0}}, a_i[BYTE_W-2:0], fill_i};
                    c_o = a_i[BYTE_W-1];
                end else begin
                    raw = {a_i[DATA_W-2:0], fill_i};
                    c_o = a_i[DATA_W-1];
                end
            end
            OP_SHR, OP_SAR: begin
                if (byte_i) begin
                    raw = {{HI_W{1'b0}},
                           (op_i == OP_SAR) ? a_i[BYTE_W-1] : fill_i,
                           a_i[BYTE_W-1:1]};
                end else begin
                    raw = {(op_i == OP_SAR) ? a_i[DATA_W-1] : fill_i,
                           a_i[DATA_W-1:1]};
                end
                c_o = a_i[0];
            end
            default: raw = '0;
        endcase
        res_o = raw & keep;
    end

endmodule

// File: rtl/alu16_flagreg.sv
module alu16_flagreg
    import alu16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [FLAG_N-1:0] mask_i,
    input  logic [FLAG_N-1:0] next_i,
    output logic [FLAG_N-1:0] q_o
);
    for (genvar i = 0; i < FLAG_N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_o[i] <= 1'b0;
            end else if (load_i && mask_i[i]) begin
                q_o[i] <= next_i[i];
            end
        end

        // R8: a flag outside the mask keeps its value on a valid cycle
        p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (load_i && !mask_i[i]) |=> $stable(q_o[i]));
    end

    // R9: no valid operation, no flag change
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(q_o));

endmodule

// File: rtl/alu16_flag_core.sv
module alu16_flag_core
    import alu16_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic [4:0]        flag_mask,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_ov,
    output logic              flag_dc
);
    alu_op_e           op;
    logic [FLAG_N-1:0] flags_q;
    logic [FLAG_N-1:0] flags_d;
    logic              arith_sub, arith_cin;
    logic [DATA_W-1:0] arith_res, sl_res;
    logic              arith_c, arith_ov, arith_dc, sl_c;
    logic              res_zero, res_neg;

    assign op = alu_op_e'(op_code);

    always_comb begin
        arith_sub = (op == OP_SUB) || (op == OP_SBB);
        unique case (op)
            OP_ADD:  arith_cin = 1'b0;
            OP_SUB:  arith_cin = 1'b1;
            OP_ADC, OP_SBB: arith_cin = flags_q[FL_C];
            default: arith_cin = 1'b0;
        endcase
    end

    alu16_arith #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_arith (
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .sub_i  (arith_sub),
        .cin_i  (arith_cin),
        .byte_i (byte_mode),
        .res_o  (arith_res),
        .c_o    (arith_c),
        .ov_o   (arith_ov),
        .dc_o   (arith_dc)
    );

    alu16_shlog #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_shlog (
        .op_i   (op),
        .byte_i (byte_mode),
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .fill_i (carry_in),
        .res_o  (sl_res),
        .c_o    (sl_c)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
                result    = arith_res;
                flag_mask = MASK_ARITH;
            end
            OP_AND, OP_OR, OP_XOR: begin
                result    = sl_res;
                flag_mask = MASK_LOGIC;
            end
            OP_SHL, OP_SHR, OP_SAR: begin
                result    = sl_res;
                flag_mask = MASK_SHIFT;
            end
            default: begin
                result    = '0;
                flag_mask = MASK_NONE;
            end
        endcase
    end

    always_comb begin
        res_zero = byte_mode ? (result[BYTE_W-1:0] == '0) : (result == '0);
        res_neg  = byte_mode ? result[BYTE_W-1] : result[DATA_W-1];
        flags_d          = '0;
        flags_d[FL_Z]    = res_zero;
        flags_d[FL_N]    = res_neg;
        flags_d[FL_C]    = (flag_mask == MASK_SHIFT) ? sl_c : arith_c;
        flags_d[FL_OV]   = arith_ov;
        flags_d[FL_DC]   = arith_dc;
    end

    alu16_flagreg u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (op_valid),
        .mask_i (flag_mask),
        .next_i (flags_d),
        .q_o    (flags_q)
    );

    assign flag_c  = flags_q[FL_C];
    assign flag_z  = flags_q[FL_Z];
    assign flag_n  = flags_q[FL_N];
    assign flag_ov = flags_q[FL_OV];
    assign flag_dc = flags_q[FL_DC];

    // R5: byte results never carry an upper byte
    p_byte_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_mode |-> (result[DATA_W-1:BYTE_W] == '0));

    // R6: logic opcodes touch only Z and N
    p_logic_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code >= 4'd4 && op_code <= 4'd6) |-> (flag_mask == 5'b01100));

    // R7: word SHL moves the top bit into carry
    p_shl_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd7 && !byte_mode)
        |=> (flag_c == $past(opnd_a[DATA_W-1])));

    // R8: unused opcodes yield nothing
    p_bad_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code > 4'd9) |-> (result == '0 && flag_mask == 5'b00000));

    // R2: a >= b never borrows on word SUB
    p_no_borrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd2 && !byte_mode && opnd_a >= opnd_b)
        |=> flag_c);

    // R3: adding opposite signs cannot overflow
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd0 && !byte_mode
         && (opnd_a[DATA_W-1] != opnd_b[DATA_W-1])) |=> !flag_ov);

endmodule

// File: tb/alu16_flag_core_tb.sv
module alu16_flag_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic        byte_mode = 1'b0;
    logic [15:0] opnd_a = 16'h0;
    logic [15:0] opnd_b = 16'h0;
    logic        carry_in = 1'b0;
    logic [15:0] result;
    logic [4:0]  flag_mask;
    logic        flag_c, flag_z, flag_n, flag_ov, flag_dc;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    alu16_flag_core dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .byte_mode(byte_mode), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .carry_in(carry_in), .result(result), .flag_mask(flag_mask),
        .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n),
        .flag_ov(flag_ov), .flag_dc(flag_dc)
    );

    // {op, byte, a, b, carry_in, expected result, expected flags {C,Z,N,OV,DC}}
    localparam int NV = 19;
    localparam logic [58:0] VEC [NV] = '{
        {4'd0, 1'b0, 16'h7FFF, 16'h0001, 1'b0, 16'h8000, 5'b00111}, // R1 R3 R4
        {4'd0, 1'b0, 16'hFFFF, 16'h0001, 1'b0, 16'h0000, 5'b11001}, // R1 R5
        {4'd1, 1'b0, 16'h1234, 16'h0001, 1'b0, 16'h1236, 5'b00000}, // R1 ADC C=1
        {4'd2, 1'b0, 16'h0005, 16'h0003, 1'b0, 16'h0002, 5'b10001}, // R2 R4
        {4'd2, 1'b0, 16'h0003, 16'h0005, 1'b0, 16'hFFFE, 5'b00100}, // R2 borrow
        {4'd3, 1'b0, 16'h0010, 16'h0001, 1'b0, 16'h000E, 5'b10000}, // R2 SBB C=0
        {4'd2, 1'b0, 16'h8000, 16'h0001, 1'b0, 16'h7FFF, 5'b10010}, // R3 sub ov
        {4'd4, 1'b0, 16'hF0F0, 16'h0F0F, 1'b0, 16'h0000, 5'b11010}, // R6
        {4'd6, 1'b0, 16'h8001, 16'h0000, 1'b0, 16'h8001, 5'b10110}, // R6
        {4'd0, 1'b1, 16'h12FF, 16'hAB01, 1'b0, 16'h0000, 5'b11001}, // R5
        {4'd0, 1'b1, 16'h007F, 16'h0001, 1'b0, 16'h0080, 5'b00111}, // R5 R3
        {4'd2, 1'b1, 16'hFF00, 16'h0001, 1'b0, 16'h00FF, 5'b00100}, // R5 R2
        {4'd7, 1'b0, 16'h8001, 16'h0000, 1'b1, 16'h0003, 5'b10000}, // R7
        {4'd8, 1'b0, 16'h0001, 16'h0000, 1'b0, 16'h0000, 5'b11000}, // R7
        {4'd9, 1'b0, 16'h8002, 16'h0000, 1'b0, 16'hC001, 5'b00100}, // R7
        {4'd9, 1'b1, 16'h1281, 16'h0000, 1'b0, 16'h00C0, 5'b10100}, // R7 R5
        {4'd5, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 5'b11000}, // R6
        {4'd12,1'b0, 16'hFFFF, 16'hFFFF, 1'b1, 16'h0000, 5'b11000}, // R8
        {4'd7, 1'b1, 16'h0080, 16'h0000, 1'b0, 16'h0000, 5'b11000}  // R7 R5
    };

    function automatic logic [4:0] mask_for(input logic [3:0] op);
        if (op <= 4'd3)      return 5'b11111;
        else if (op <= 4'd6) return 5'b01100;
        else if (op <= 4'd9) return 5'b11100;
        else                 return 5'b00000;
    endfunction

    function automatic logic [4:0] flags_now();
        return {flag_c, flag_z, flag_n, flag_ov, flag_dc};
    endfunction

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 check("R10 reset flags", {11'd0, flags_now()}, 16'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_code   = VEC[i][58:55];
            byte_mode = VEC[i][54];
            opnd_a    = VEC[i][53:38];
            opnd_b    = VEC[i][37:22];
            carry_in  = VEC[i][21];
            op_valid  = 1'b1;
            #1;
            check($sformatf("R1-8 vec%0d result", i), result, VEC[i][20:5]);
            check($sformatf("R8 vec%0d mask", i), {11'd0, flag_mask},
                  {11'd0, mask_for(VEC[i][58:55])});
            @(negedge clk);
            op_valid = 1'b0;
            #1 check($sformatf("R1-7 vec%0d flags", i),
                     {11'd0, flags_now()}, {11'd0, VEC[i][4:0]});
        end

        // R9: op_valid low holds flags (currently 11000)
        @(negedge clk);
        op_code = 4'd0; byte_mode = 1'b0;
        opnd_a = 16'h7FFF; opnd_b = 16'h0001; op_valid = 1'b0;
        repeat (2) @(negedge clk);
        #1 check("R9 idle hold", {11'd0, flags_now()}, 16'h0018);

        // R10: reset mid-run clears flags
        rst_n = 1'b0;
        #2 check("R10 async clear", {11'd0, flags_now()}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule